// File: doc/BRIEF.md
# Phased Interrupt Traffic Sequencer

This block turns the system clock into a square-wave frame with a high half and a low half. Each half carries its own train of evenly spaced interrupt ticks. The first tick of a half falls on the first cycle of that half. Each tick first runs through a short fixed deferral. It then opens a transfer whose kind depends on the half in which the tick was raised.

A high-half tick opens an acquisition burst. The burst accepts a parameter-sized number of words on a ready/valid input and pushes each one into an internal queue. A low-half tick opens an actuation burst. That burst pops words from the queue onto a ready/valid output stream. If a tick arrives while the previous burst of its kind is still open, the tick is held back and served afterwards. Two sticky flags record a push that hit a full queue and a pop that found the queue empty.

The frame length, tick count, deferral time and clock rate are parameters. So are the two payload sizes in bytes, which are rounded up to whole data words. The defaults give a 1 ms frame, 20 ticks per half and a 50 ns deferral at a 50 MHz clock.

Top module: `phase_tick_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `phase_hi` is 1, `in_ready` and `out_valid` are 0, both sticky flags are 0, the queue is empty, and `tick` is 1. That tick is the first tick of a new high half.
- R2: Each half lasts HALF_US microseconds' worth of clock cycles. `phase_hi` is 1 during the first half after reset and toggles at the end of every half.
- R3: Exactly TICKS_PER_HALF single-cycle `tick` pulses occur in each half. They fall on cycle 0 of the half and then every half/TICKS_PER_HALF cycles.
- R4: A tick takes effect after ceil(DELAY_NS × clock rate) cycles. With an idle burst engine, `in_ready` (high-half tick) or `out_valid` (low-half tick, queue not empty) rises that many cycles plus one after the cycle in which `tick` was seen.
- R5: An acquisition burst keeps `in_ready` high until it has completed its word count of handshakes. Each accepted word is pushed into the queue in arrival order.
- R6: An actuation burst presents the queue head on `out_data` and pops it on each handshake, so words leave in the order they were accepted. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R7: When an actuation burst finds the queue empty, `underflow` is set and stays set until reset, that burst ends, and `out_valid` stays low.
- R8: A word accepted while the queue holds FIFO_DEPTH words is dropped, so it never appears on the output. The acceptance sets `overflow`, which stays set until reset.
- R9: A tick whose burst engine is busy is held, not lost. Every held tick later opens its own full burst.
- R10: A burst moves ceil(bytes / (DATA_W/8)) words, using ACQ_BYTES for acquisition and ACT_BYTES for actuation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Acquisition word offered |
| in_ready | output | 1 | Acquisition burst open, word will be taken |
| in_data | input | DATA_W | Acquisition word |
| out_valid | output | 1 | Actuation word available |
| out_ready | input | 1 | Downstream takes the actuation word |
| out_data | output | DATA_W | Actuation word (queue head) |
| phase_hi | output | 1 | 1 in the high half of the frame, 0 in the low half |
| tick | output | 1 | One-cycle interrupt tick strobe |
| overflow | output | 1 | Sticky: a word was dropped at a full queue |
| underflow | output | 1 | Sticky: an actuation burst met an empty queue |

## Verification
Several behaviours are checked on every cycle by properties. These cover the tick count of each half, the phase flip at the half boundary, the queue occupancy bound, and the hold of a stalled output word. They also cover the stickiness of both flags, the per-burst word limit, and the rule that a deferred tick always leaves its engine busy or holding work. Other behaviours only show in the bench's scenarios. These are the exact cycle on which a deferred tick opens a burst, the order and identity of words from input to output, the loss of a word pushed into a full queue, the moment underflow appears, and the service of ticks that were held back while an engine was busy.

// File: rtl/pts_pkg.sv
package pts_pkg;

  // Cycles in one half of the frame.
  function automatic int half_cycles(input int clk_khz, input int half_us);
    return (clk_khz * half_us) / 1000;
  endfunction

  // Spacing of ticks inside one half.
  function automatic int tick_gap(input int half_cyc, input int ticks);
    return (half_cyc / ticks > 0) ? half_cyc / ticks : 1;
  endfunction

  // Deferral in cycles, rounded up.
  function automatic int defer_cycles(input int delay_ns, input int clk_khz);
    return (delay_ns * clk_khz + 999_999) / 1_000_000;
  endfunction

  // Words needed to carry a payload, at least one.
  function automatic int burst_words(input int bytes, input int data_w);
    int bpw;
    bpw = (data_w / 8 > 0) ? data_w / 8 : 1;
    return (bytes + bpw - 1) / bpw > 0 ? (bytes + bpw - 1) / bpw : 1;
  endfunction

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

endpackage

// File: rtl/pts_frame_timer.sv
module pts_frame_timer #(
  parameter int GAP   = 1250,
  parameter int TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  output logic phase_hi,
  output logic tick
);
  import pts_pkg::*;

  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam int SW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [GW-1:0] gap_q;
  logic [SW-1:0] slot_q;
  phase_e        ph_q;
  logic          last_gap, last_slot, half_wrap;

  assign last_gap  = (gap_q == GW'(GAP - 1));
  assign last_slot = (slot_q == SW'(TICKS - 1));
  assign half_wrap = last_gap && last_slot;
  assign tick      = (gap_q == '0);
  assign phase_hi  = (ph_q == PH_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      slot_q <= '0;
      ph_q   <= PH_HIGH;
    end else if (last_gap) begin
      gap_q <= '0;
      if (last_slot) begin
        slot_q <= '0;
        ph_q   <= (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // Independent count of tick strobes in the current half.
  logic [SW:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst)            seen_q <= '0;
    else if (half_wrap) seen_q <= '0;
    else                seen_q <= seen_q + (SW+1)'(tick);
  end

  AST_TICKS_PER_HALF: assert property (@(posedge clk) disable iff (rst)
    half_wrap |-> (int'(seen_q) + int'(tick) == TICKS)); // R3
  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
    half_wrap |=> (phase_hi != $past(phase_hi))); // R2
  AST_PHASE_STEADY: assert property (@(posedge clk) disable iff (rst)
    !half_wrap |=> $stable(phase_hi)); // R2

endmodule

// File: rtl/pts_tick_delay.sv
module pts_tick_delay #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  input  logic phase_in,
  output logic tick_out,
  output logic phase_out
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign tick_out  = tick_in;
      assign phase_out = phase_in;
    end else begin : g_pipe
      logic [STAGES-1:0] vld_q, ph_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= '0;
          ph_q  <= '0;
        end else begin
          vld_q[0] <= tick_in;
          ph_q[0]  <= phase_in;
          for (int i = 1; i < STAGES; i++) begin
            vld_q[i] <= vld_q[i-1];
            ph_q[i]  <= ph_q[i-1];
          end
        end
      end
      assign tick_out  = vld_q[STAGES-1];
      assign phase_out = ph_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pts_word_fifo.sv
module pts_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign dout  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wr_q <= bump(wr_q);
      if (rd_ok) rd_q <= bump(rd_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= DEPTH); // R8
  AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> full); // R8
  AST_FIFO_POP_GUARD: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R7

endmodule

// File: rtl/pts_burst_gate.sv
module pts_burst_gate #(
  parameter int WORDS    = 1,
  parameter int PEND_MAX = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic arrive,
  input  logic step,
  input  logic abort,
  output logic active,
  output logic waiting
);
  localparam int RW = $clog2(WORDS + 1);
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [RW-1:0] rem_q;
  logic [PW-1:0] pend_q;
  logic          act_q, start, finish;

  assign start   = !act_q && ((pend_q != '0) || arrive);
  assign finish  = act_q && (abort || (step && rem_q == RW'(1)));
  assign active  = act_q;
  assign waiting = (pend_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      rem_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      case ({arrive, start})
        2'b10:   pend_q <= (pend_q == PW'(PEND_MAX)) ? pend_q : pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
      if (start) begin
        act_q <= 1'b1;
        rem_q <= RW'(WORDS);
      end else if (finish) begin
        act_q <= 1'b0;
        rem_q <= '0;
      end else if (act_q && step) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  // Independent count of beats in the open burst.
  logic [RW-1:0] beats_q;
  always_ff @(posedge clk) begin
    if (rst)               beats_q <= '0;
    else if (start)        beats_q <= '0;
    else if (act_q && step) beats_q <= beats_q + 1'b1;
  end

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
    (act_q && step) |-> (int'(beats_q) < WORDS)); // R10
  AST_HELD_TICK: assert property (@(posedge clk) disable iff (rst)
    arrive |=> (act_q || pend_q != '0)); // R9

endmodule

// File: rtl/phase_tick_sequencer.sv
module phase_tick_sequencer #(
  parameter int DATA_W         = 32,
  parameter int FIFO_DEPTH     = 16,
  parameter int CLK_KHZ        = 50000,
  parameter int HALF_US        = 500,
  parameter int TICKS_PER_HALF = 20,
  parameter int DELAY_NS       = 50,
  parameter int ACQ_BYTES      = 8,
  parameter int ACT_BYTES      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              phase_hi,
  output logic              tick,
  output logic              overflow,
  output logic              underflow
);
  import pts_pkg::*;

  localparam int HALF_CYC = half_cycles(CLK_KHZ, HALF_US);
  localparam int GAP      = tick_gap(HALF_CYC, TICKS_PER_HALF);
  localparam int DLY      = defer_cycles(DELAY_NS, CLK_KHZ);
  localparam int ACQ_W    = burst_words(ACQ_BYTES, DATA_W);
  localparam int ACT_W    = burst_words(ACT_BYTES, DATA_W);
  localparam int PEND_MAX = 2 * TICKS_PER_HALF;

  // Named internal events.
  logic dly_tick, dly_phase;
  logic acq_go, act_go;
  logic acq_active, act_active, acq_waiting, act_waiting;
  logic acq_beat, act_beat, push_drop, pop_starved;
  logic q_empty, q_full;
  logic ovf_q, unf_q;

  pts_frame_timer #(.GAP(GAP), .TICKS(TICKS_PER_HALF)) u_timer (
    .clk(clk), .rst(rst), .phase_hi(phase_hi), .tick(tick)
  );

  pts_tick_delay #(.STAGES(DLY)) u_defer (
    .clk(clk), .rst(rst), .tick_in(tick), .phase_in(phase_hi),
    .tick_out(dly_tick), .phase_out(dly_phase)
  );

  assign acq_go = dly_tick && dly_phase;
  assign act_go = dly_tick && !dly_phase;

  pts_burst_gate #(.WORDS(ACQ_W), .PEND_MAX(PEND_MAX)) u_acq (
    .clk(clk), .rst(rst), .arrive(acq_go), .step(acq_beat), .abort(1'b0),
    .active(acq_active), .waiting(acq_waiting)
  );

  pts_burst_gate #(.WORDS(ACT_W), .PEND_MAX(PEND_MAX)) u_act (
    .clk(clk), .rst(rst), .arrive(act_go), .step(act_beat), .abort(pop_starved),
    .active(act_active), .waiting(act_waiting)
  );

  assign in_ready    = acq_active;
  assign acq_beat    = in_valid && acq_active;
  assign push_drop   = acq_beat && q_full;
  assign out_valid   = act_active && !q_empty;
  assign act_beat    = out_valid && out_ready;
  assign pop_starved = act_active && q_empty;

  pts_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(acq_beat), .din(in_data),
    .pop(act_beat), .dout(out_data), .empty(q_empty), .full(q_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_q || push_drop;
      unf_q <= unf_q || pop_starved;
    end
  end

  assign overflow  = ovf_q;
  assign underflow = unf_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && out_data == $past(out_data))); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R8
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow); // R7
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    push_drop |=> overflow); // R8
  AST_STARVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    pop_starved |-> !out_valid); // R7
  AST_ACT_HELD: assert property (@(posedge clk) disable iff (rst)
    (act_go && act_active) |=> (act_active || act_waiting)); // R9
  AST_ACQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (acq_go && acq_active) |=> (acq_active || acq_waiting)); // R9

endmodule

// File: tb/phase_tick_sequencer_test.sv
module phase_tick_sequencer_test;
  localparam int W      = 16;
  localparam int HALF   = 1000;  // 50 MHz * 20 us
  localparam int SPACE  = 50;    // 1000 / 20
  localparam int DEFER  = 3;     // ceil(50 ns / 20 ns)
  localparam int NVEC   = 8;
  localparam logic [W-1:0] VEC [NVEC] = '{16'h1111, 16'hA5A5, 16'h0F0F, 16'h8001,
                                          16'h7E7E, 16'h0000, 16'hFFFF, 16'h3C3C};

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, phase_hi, tick, overflow, underflow;
  logic [W-1:0] out_data;
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  phase_tick_sequencer #(
    .DATA_W(W), .FIFO_DEPTH(8), .CLK_KHZ(50000), .HALF_US(20),
    .TICKS_PER_HALF(20), .DELAY_NS(50), .ACQ_BYTES(3), .ACT_BYTES(4)
  ) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .phase_hi(phase_hi), .tick(tick), .overflow(overflow), .underflow(underflow)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] w);
    @(negedge clk); in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      report();
    end
  end

  initial begin
    int hi_t, lo_t, pos_bad, ph_bad, rdy_at, seen_out, got;
    logic [W-1:0] held;

    // R1: reset state
    @(negedge clk);
    check(phase_hi && !in_ready && !out_valid && !overflow && !underflow, "R1 during reset",
          {phase_hi, in_ready, out_valid, overflow, underflow}, 5'b10000);
    do_reset();
    check(phase_hi == 1'b1, "R1 phase after release", phase_hi, 1);
    check(tick == 1'b1, "R1 first tick", tick, 1);
    check(!in_ready && !out_valid, "R1 handshakes idle", {in_ready, out_valid}, 0);
    check(!overflow && !underflow, "R1 flags clear", {overflow, underflow}, 0);

    // R2 R3 R4 R7: one whole frame with no input data and empty queue
    hi_t = 0; lo_t = 0; pos_bad = 0; ph_bad = 0; rdy_at = -1; seen_out = 0;
    for (int i = 0; i < 2 * HALF; i++) begin
      if (tick != ((cyc % SPACE) == 0)) pos_bad++;
      if (phase_hi != (cyc < HALF)) ph_bad++;
      if (tick && phase_hi) hi_t++;
      if (tick && !phase_hi) lo_t++;
      if (in_ready && rdy_at < 0) rdy_at = cyc;
      if (out_valid) seen_out++;
      @(negedge clk);
    end
    check(hi_t == 20, "R3 ticks in high half", hi_t, 20);
    check(lo_t == 20, "R3 ticks in low half", lo_t, 20);
    check(pos_bad == 0, "R3 tick positions", pos_bad, 0);
    check(ph_bad == 0, "R2 phase timing", ph_bad, 0);
    check(phase_hi == 1'b1, "R2 phase returns high", phase_hi, 1);
    check(rdy_at == DEFER + 1, "R4 acquisition opens after deferral", rdy_at, DEFER + 1);
    check(seen_out == 0, "R7 no output on empty queue", seen_out, 0);
    check(underflow == 1'b1, "R7 underflow sticky", underflow, 1);
    check(overflow == 1'b0, "R8 no overflow without data", overflow, 0);

    // Table walk: fill the queue, overflow once, then drain in order
    do_reset();
    for (int k = 0; k < NVEC; k++) begin
      push(VEC[k]);
      if (k == 1) check(in_ready == 1'b0, "R10 acquisition burst is two words", in_ready, 0);
    end
    check(overflow == 1'b0, "R8 full queue without drop", overflow, 0);
    push(16'hDEAD);
    check(overflow == 1'b1, "R8 overflow on ninth word", overflow, 1);
    wait_to(HALF);
    while (!out_valid) @(negedge clk);
    check(cyc == HALF + DEFER + 1, "R4 actuation opens after deferral", cyc, HALF + DEFER + 1);
    held = out_data;
    repeat (3) begin
      @(negedge clk);
      check(out_valid && out_data == held, "R6 stalled word holds", out_data, held);
    end
    out_ready = 1'b1;
    got = 0;
    while (cyc < 2 * HALF - 10) begin
      if (out_valid) begin
        if (got < NVEC)
          check(out_data == VEC[got], "R5 R6 word order", out_data, VEC[got]);
        else
          check(1'b0, "R8 dropped word appeared", out_data, 0);
        got++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(got == NVEC, "R8 word count out", got, NVEC);
    check(underflow == 1'b1, "R7 underflow after drain", underflow, 1);

    // R9: ticks held while the acquisition engine is busy
    do_reset();
    wait_to(120);
    for (int k = 0; k < 6; k++) push(16'h4000 + 16'(k));
    check(cyc < 150 && in_ready == 1'b0, "R9 three held bursts served", in_ready, 0);
    wait_to(SPACE * 3 + DEFER + 1);
    check(in_ready == 1'b1, "R9 next tick opens burst", in_ready, 1);
    check(overflow == 1'b0, "R9 no drop", overflow, 0);

    done = 1'b1;
    report();
  end
endmodule